// File: doc/BRIEF.md
# Four-level serial receive buffer

This block turns a serial bit stream into bytes and keeps the finished bytes in a short queue until the host takes them. Each incoming bit comes with a strobe. The bits pass through an input shift register, least significant bit first. When a byte is complete it drops into the lowest of three holding stages.

The held bytes climb toward the top stage, one stage per pulse of an internal transfer enable. A byte only moves into a stage that is empty. The top stage is the receive buffer seen by the host. A flag says when it holds a byte. A host read empties the top stage, and the next queued byte then rises into it on the following transfer pulses.

Together, the shift register and the three stages give four levels of buffering. A byte that finishes while the lowest stage is still full is dropped, and a sticky overrun flag records the loss.

Top module: `rx_quad_buffer`

## Requirements
- R1: A synchronous active-high reset empties every stage and discards any partly assembled byte: afterwards rx_avail=0, rx_data=0 and rx_overrun=0.
- R2: A bit is taken only in a cycle with ser_valid high. The first bit taken becomes bit 0 of the byte. The byte is complete on the 8th taken bit, and ser_bit is ignored while ser_valid is low.
- R3: A completed byte is written into the lowest stage on the same clock edge that takes its last bit, provided that stage was empty before that edge.
- R4: On an edge with xfer_en high, a byte moves up one stage only if the stage above was empty before that edge. Without xfer_en, no byte changes stage.
- R5: rx_avail is high exactly when the top stage holds a byte. rx_data then shows that byte, and shows 0 when the top stage is empty.
- R6: A host_rd while rx_avail is high empties the top stage on that edge. The next queued byte reaches the top on a later edge with xfer_en high.
- R7: A host_rd while rx_avail is low has no effect.
- R8: If a byte completes while the lowest stage is full, that byte is discarded and rx_overrun goes high. rx_overrun stays high until reset.
- R9: Bytes reach the host in the order in which their serial bits arrived.
- R10: With no reads, three completed bytes are held without loss or overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_bit | input | 1 | Serial data bit |
| ser_valid | input | 1 | ser_bit is valid this cycle |
| xfer_en | input | 1 | Internal enable that moves bytes up one stage |
| host_rd | input | 1 | Host read of the receive buffer |
| rx_data | output | 8 | Byte in the top stage, 0 when empty |
| rx_avail | output | 1 | Top stage holds a byte |
| rx_overrun | output | 1 | Sticky flag for a byte lost to a full lowest stage |

## Verification
The assertions check the following on every cycle:
- idle cycles freeze the bit counter;
- a stage never takes a byte while it is still full;
- an unmoved stage keeps its contents;
- a read empties the top;
- an empty top stays empty without a transfer pulse;
- the overrun flag never falls.

Several properties span more than a few cycles, so only the bench scenarios, checked against the queue model, can show them:
- bit order within a byte;
- first-in first-out order across bytes;
- full capacity of three bytes;
- the byte that is lost on overrun;
- a reset that cuts a byte short.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int RXQ_DATA_W = 8;
  localparam int RXQ_DEPTH  = 3;

  // A byte may step up when the enable is present, the stage holds a byte
  // and the stage above held nothing before this edge.
  function automatic logic can_advance(input logic en, input logic here_full,
                                       input logic above_full);
    return en & here_full & ~above_full;
  endfunction

  // The lowest stage accepts a finished byte only when it was empty.
  function automatic logic can_load(input logic done, input logic bottom_full);
    return done & ~bottom_full;
  endfunction
endpackage

// File: rtl/rxq_deser.sv
module rxq_deser #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_bit,
  input  logic              ser_valid,
  output logic              byte_done,
  output logic [DATA_W-1:0] byte_val
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;

  // New bits enter at the top and travel down, so the first bit ends at bit 0.
  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] cur,
                                                 input logic b);
    return {b, cur[DATA_W-1:1]};
  endfunction

  assign byte_done = ser_valid && (bit_cnt == LAST);
  assign byte_val  = shift_in(shreg, ser_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (ser_valid) begin
      shreg   <= byte_val;
      bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
    end
  end

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !ser_valid |=> $stable(bit_cnt));
  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> (bit_cnt == '0));
endmodule

// File: rtl/rxq_stage.sv
module rxq_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arrive,
  input  logic              leave,
  input  logic [DATA_W-1:0] din,
  output logic              full,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      dout <= '0;
    end else if (arrive) begin
      full <= 1'b1;
      dout <= din;
    end else if (leave) begin
      full <= 1'b0;
    end
  end

  a_r8_no_overwrite: assert property (@(posedge clk) disable iff (rst)
    (full && !leave) |-> !arrive);
  a_r4_stage_hold: assert property (@(posedge clk) disable iff (rst)
    (!arrive && !leave) |=> ($stable(full) && $stable(dout)));
endmodule

// File: rtl/rx_quad_buffer.sv
module rx_quad_buffer
  import rxq_pkg::*;
#(
  parameter int DATA_W = RXQ_DATA_W,
  parameter int DEPTH  = RXQ_DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_bit,
  input  logic              ser_valid,
  input  logic              xfer_en,
  input  logic              host_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_avail,
  output logic              rx_overrun
);
  localparam int TOP = DEPTH - 1;

  logic              byte_done;
  logic [DATA_W-1:0] byte_val;
  logic              arrive [DEPTH];
  logic              leave  [DEPTH];
  logic              full   [DEPTH];
  logic [DATA_W-1:0] sdata  [DEPTH];
  logic [DATA_W-1:0] sin    [DEPTH];
  logic              overrun_evt;

  rxq_deser #(.DATA_W(DATA_W)) deser_i (
    .clk(clk), .rst(rst), .ser_bit(ser_bit), .ser_valid(ser_valid),
    .byte_done(byte_done), .byte_val(byte_val)
  );

  assign arrive[0]   = can_load(byte_done, full[0]);
  assign sin[0]      = byte_val;
  assign overrun_evt = byte_done & full[0];
  assign leave[TOP]  = host_rd & full[TOP];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    rxq_stage #(.DATA_W(DATA_W)) stage_i (
      .clk(clk), .rst(rst), .arrive(arrive[i]), .leave(leave[i]),
      .din(sin[i]), .full(full[i]), .dout(sdata[i])
    );
    if (i < TOP) begin : g_link
      assign leave[i]    = can_advance(xfer_en, full[i], full[i+1]);
      assign arrive[i+1] = leave[i];
      assign sin[i+1]    = sdata[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rx_overrun <= 1'b0;
    else if (overrun_evt) rx_overrun <= 1'b1;
  end

  assign rx_avail = full[TOP];
  assign rx_data  = full[TOP] ? sdata[TOP] : '0;

  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    (host_rd && rx_avail) |=> !rx_avail);
  a_r4_no_xfer_empty: assert property (@(posedge clk) disable iff (rst)
    (!xfer_en && !rx_avail) |=> !rx_avail);
  a_r7_empty_read: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !rx_avail && !xfer_en) |=> (!rx_avail && rx_data == '0));
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    rx_overrun |=> rx_overrun);
  a_r8_flag_on_loss: assert property (@(posedge clk) disable iff (rst)
    overrun_evt |=> rx_overrun);
endmodule

// File: tb/rx_quad_buffer_tb_top.sv
module rx_quad_buffer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_bit = 1'b0, ser_valid = 1'b0, xfer_en = 1'b0, host_rd = 1'b0;
  logic [7:0] rx_data;
  logic rx_avail, rx_overrun;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_quad_buffer dut_i (
    .clk(clk), .rst(rst), .ser_bit(ser_bit), .ser_valid(ser_valid),
    .xfer_en(xfer_en), .host_rd(host_rd), .rx_data(rx_data),
    .rx_avail(rx_avail), .rx_overrun(rx_overrun)
  );

  // Reference model: oldest byte first, with its stage number (0 lowest, 2 top)
  logic [7:0] mq[$];
  int         mp[$];
  int         m_cnt;
  logic [7:0] m_acc;
  bit         m_ovr;
  int         m_n;
  bit         m_busy, m_pop;
  int         m_newp[$];

  always @(posedge clk) begin
    if (rst) begin
      mq.delete(); mp.delete(); m_cnt = 0; m_acc = 8'h00; m_ovr = 0;
    end else begin
      m_n = mq.size();
      m_busy = (m_n > 0) && (mp[m_n-1] == 0);
      m_pop  = (m_n > 0) && (mp[0] == 2) && host_rd;
      m_newp.delete();
      for (int k = 0; k < m_n; k++) begin
        if (xfer_en && mp[k] < 2 && (k == 0 || mp[k-1] != mp[k] + 1))
          m_newp.push_back(mp[k] + 1);
        else
          m_newp.push_back(mp[k]);
      end
      mp = m_newp;
      if (m_pop) begin
        void'(mq.pop_front()); void'(mp.pop_front());
      end
      if (ser_valid) begin
        m_acc[m_cnt] = ser_bit;
        if (m_cnt == 7) begin
          if (m_busy) m_ovr = 1;
          else begin mq.push_back(m_acc); mp.push_back(0); end
          m_cnt = 0; m_acc = 8'h00;
        end else m_cnt++;
      end
    end
  end

  function automatic bit exp_avail();
    return (mq.size() > 0) && (mp[0] == 2);
  endfunction

  function automatic logic [7:0] exp_data();
    return exp_avail() ? mq[0] : 8'h00;
  endfunction

  // Cycle-by-cycle comparison with the model (R5 outputs, R8 flag)
  always @(negedge clk) begin
    if (!rst && !done) begin
      total++;
      if (rx_avail !== exp_avail() || rx_data !== exp_data()) begin
        bad++;
        $display("FAIL R5 model: avail=%0b data=%02h expected avail=%0b data=%02h",
                 rx_avail, rx_data, exp_avail(), exp_data());
      end
      total++;
      if (rx_overrun !== m_ovr) begin
        bad++;
        $display("FAIL R8 model: overrun=%0b expected %0b", rx_overrun, m_ovr);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ser_valid = 1'b1; ser_bit = b[i];
      @(negedge clk); ser_valid = 1'b0; ser_bit = ~b[i];
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic pulse_xfer();
    @(negedge clk); xfer_en = 1'b1;
    @(negedge clk); xfer_en = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk); host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 avail after reset", rx_avail, 0);
    chk("R1 data after reset", rx_data, 0);
    chk("R1 overrun after reset", rx_overrun, 0);

    // One byte with gaps, no transfer enable yet
    send_bits(8'hA5, 8, 2);
    idle(2);
    chk("R4 no move without xfer_en", rx_avail, 0);
    pulse_xfer();
    chk("R4 one step after one pulse", rx_avail, 0);
    pulse_xfer();
    chk("R3 byte reaches top", rx_avail, 1);
    chk("R2 lsb-first byte", rx_data, 8'hA5);

    do_read();
    chk("R6 read empties top", rx_avail, 0);
    do_read();
    chk("R7 empty read avail", rx_avail, 0);
    chk("R7 empty read data", rx_data, 0);
    chk("R7 empty read overrun", rx_overrun, 0);

    // Three bytes with the enable held on
    @(negedge clk); xfer_en = 1'b1;
    send_bits(8'h3C, 8, 0);
    send_bits(8'h5A, 8, 0);
    send_bits(8'hC3, 8, 0);
    idle(4);
    chk("R9 oldest on top", rx_data, 8'h3C);
    chk("R10 three held no overrun", rx_overrun, 0);
    do_read();
    chk("R6 gap after read", rx_avail, 0);
    idle(1);
    chk("R6 next byte pulled up", rx_data, 8'h5A);

    // Fill, then overflow
    send_bits(8'h11, 8, 0);
    idle(3);
    send_bits(8'h22, 8, 0);
    idle(1);
    chk("R8 overrun set", rx_overrun, 1);
    chk("R9 order 1", rx_data, 8'h5A);
    do_read(); idle(2);
    chk("R9 order 2", rx_data, 8'hC3);
    do_read(); idle(3);
    chk("R9 order 3", rx_data, 8'h11);
    do_read(); idle(3);
    chk("R8 lost byte absent", rx_avail, 0);
    chk("R8 overrun sticky", rx_overrun, 1);

    // Reset cuts a byte short
    send_bits(8'hFF, 4, 0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 overrun cleared", rx_overrun, 0);
    chk("R1 avail cleared", rx_avail, 0);
    send_bits(8'h96, 8, 1);
    idle(3);
    chk("R1 partial byte discarded", rx_data, 8'h96);
    do_read();

    // Mixed traffic checked against the model
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      ser_valid = ($urandom % 3) != 0;
      ser_bit   = $urandom % 2;
      xfer_en   = ($urandom % 4) == 0;
      host_rd   = ($urandom % 16) == 0;
    end
    @(negedge clk);
    ser_valid = 1'b0; xfer_en = 1'b0; host_rd = 1'b0;
    idle(2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule